// File: doc/BRIEF.md
# Banked Control Register File

This block holds the small set of control registers that sit beside a processor's general register file. It contains a packed status word with a backup copy, a condition bit, two saved program counters, a second-level saved status byte, two plain scratch registers, and a pair of stack-pointer slots. The slots are banked against the live stack pointer that the core uses for pushes and pops.

A stack-mode bit in the status word selects which bank is live. When a status write flips that bit, the block exchanges the live pointer with the stored copy of the other bank on the same clock edge.

Software reaches every register through one indexed read port, which is combinational, and one indexed write port, which takes effect on the rising edge. The core sees the live stack pointer on `sp_o`. It can overwrite the live pointer through `sp_we_i` and `sp_data_i`.

Top module: `ctrl_reg_bank`

## Requirements
- R1: Reading index 0 returns a status word. Bits 31:16 are zero. Bits 15, 14 and 8 are bits 7, 6 and 0 of the backup status byte. Bits 7 and 6 are bits 7 and 6 of the current status byte. Bit 0 is the condition bit. All other bits read zero.
- R2: Writing index 0 does three things. It loads the backup status byte from data bits 15:8. It loads the current status byte from bits 7:0. It sets the condition bit from bit 0.
- R3: The stack-mode bit is bit 7 of the current status byte. When it is 0, the interrupt stack is live. In that mode, index 2 reads and writes the live pointer `sp_o`, and index 3 reads and writes the stored user slot. When the bit is 1, index 3 targets the live pointer and index 2 targets the stored interrupt slot.
- R4: A status write that changes the stack-mode bit from 0 to 1 has two effects on the edge. The old live pointer goes into the interrupt slot. The live pointer is loaded from the user slot.
- R5: A status write that changes the stack-mode bit from 1 to 0 has two effects on the edge. The old live pointer goes into the user slot. The live pointer is loaded from the interrupt slot.
- R6: A status write that leaves the stack-mode bit unchanged does not move any stack pointer.
- R7: Index 6 and index 8 are the two saved program counters. Writes store all bits. Reads always return bit 0 as zero.
- R8: Index 7 is the second-level saved status. A write keeps data bits 7:0. A read returns that byte masked with 0xC1.
- R9: Index 1 reads and writes only the condition bit, in bit 0, and its other bits read zero. Indices 4 and 5 are full-width plain storage.
- R10: Indices 9 to 15 read zero. Writes to them change no register.
- R11: When `sp_we_i` is high, `sp_data_i` loads the live pointer on the edge. The only exception is an indexed write in the same cycle that writes the live pointer itself, whether by a swap or through index 2 or 3. That indexed write takes priority.
- R12: An active-low asynchronous reset clears every register, the condition bit, the stack-mode bit and the live pointer to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_idx_i | input | 4 | Read register index |
| rd_data_o | output | DATA_W | Read data, combinational |
| wr_en_i | input | 1 | Write enable for indexed port |
| wr_idx_i | input | 4 | Write register index |
| wr_data_i | input | DATA_W | Write data |
| sp_we_i | input | 1 | Core update of live stack pointer |
| sp_data_i | input | DATA_W | Core value for live stack pointer |
| sp_o | output | DATA_W | Live stack pointer |

## Verification
Five data patterns are written to all sixteen indices in turn, and every index plus `sp_o` is read back after each write. All-ones and all-zeros patterns expose the read masks on the status, saved-status and saved-PC registers. Alternating patterns toggle the stack-mode bit on status writes, so the bench sees swaps in both directions interleaved with banked reads. Core pointer writes on odd indices show whether indexed writes to the live pointer take priority. A directed sequence then separates the 0-to-1 swap, the 1-to-0 swap and a status write that keeps the mode.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int unsigned CRB_IDX_W = 4;
  typedef logic [CRB_IDX_W-1:0] crb_idx_t;

  localparam crb_idx_t IDX_STATUS = 4'd0;
  localparam crb_idx_t IDX_COND   = 4'd1;
  localparam crb_idx_t IDX_ISP    = 4'd2;
  localparam crb_idx_t IDX_USP    = 4'd3;
  localparam crb_idx_t IDX_SCR0   = 4'd4;
  localparam crb_idx_t IDX_SCR1   = 4'd5;
  localparam crb_idx_t IDX_BPC    = 4'd6;
  localparam crb_idx_t IDX_BBST   = 4'd7;
  localparam crb_idx_t IDX_BBPC   = 4'd8;

  localparam int unsigned SCR_N  = 2;
  localparam int unsigned BKPC_N = 2;
  localparam int unsigned SM_BIT = 7;
endpackage

// File: rtl/crb_status.sv
module crb_status
  import crb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_we_i,
  input  logic              cond_we_i,
  input  logic              bb_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [15:0]       status_o,
  output logic [7:0]        bbst_o,
  output logic              cond_o,
  output logic              sm_o
);
  // only bits that are ever read back are kept: {b7,b6} / {b7,b6,b0}
  logic [1:0] cur_q;
  logic [2:0] bak_q;
  logic [2:0] bb_q;
  logic       cond_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      bak_q  <= '0;
      bb_q   <= '0;
      cond_q <= 1'b0;
    end else begin
      if (st_we_i) begin
        cur_q  <= wdata_i[7:6];
        bak_q  <= {wdata_i[15:14], wdata_i[8]};
        cond_q <= wdata_i[0];
      end
      if (cond_we_i) cond_q <= wdata_i[0];
      if (bb_we_i)   bb_q   <= {wdata_i[7:6], wdata_i[0]};
    end
  end

  assign status_o = {bak_q[2:1], 5'b0, bak_q[0], cur_q, 5'b0, cond_q};
  assign bbst_o   = {bb_q[2:1], 5'b0, bb_q[0]};
  assign cond_o   = cond_q;
  assign sm_o     = cur_q[1];
endmodule

// File: rtl/crb_sp_bank.sv
module crb_sp_bank #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sm_i,
  input  logic              swap_i,
  input  logic              isp_we_i,
  input  logic              usp_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              core_we_i,
  input  logic [DATA_W-1:0] core_data_i,
  output logic [DATA_W-1:0] live_o,
  output logic [DATA_W-1:0] isp_slot_o,
  output logic [DATA_W-1:0] usp_slot_o
);
  logic [DATA_W-1:0] live_q, isp_q, usp_q;
  logic [DATA_W-1:0] live_n, isp_n, usp_n;

  // core update first, indexed accesses override it
  always_comb begin
    live_n = live_q;
    isp_n  = isp_q;
    usp_n  = usp_q;
    if (core_we_i) live_n = core_data_i;
    if (swap_i) begin
      if (sm_i) begin
        usp_n  = live_q;
        live_n = isp_q;
      end else begin
        isp_n  = live_q;
        live_n = usp_q;
      end
    end else begin
      if (isp_we_i) begin
        if (!sm_i) live_n = wdata_i;
        else       isp_n  = wdata_i;
      end
      if (usp_we_i) begin
        if (sm_i)  live_n = wdata_i;
        else       usp_n  = wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      isp_q  <= '0;
      usp_q  <= '0;
    end else begin
      live_q <= live_n;
      isp_q  <= isp_n;
      usp_q  <= usp_n;
    end
  end

  assign live_o     = live_q;
  assign isp_slot_o = isp_q;
  assign usp_slot_o = usp_q;
endmodule

// File: rtl/crb_store.sv
module crb_store #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N       = 2,
  parameter bit          CLR_LSB = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o [N]
);
  localparam logic [DATA_W-1:0] RD_MASK = CLR_LSB ? ~DATA_W'(1) : '1;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [DATA_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ent_q <= '0;
      else if (we_i[g]) ent_q <= wdata_i;
    end
    assign q_o[g] = ent_q & RD_MASK;
  end
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import crb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sp_we_i,
  input  logic [DATA_W-1:0] sp_data_i,
  output logic [DATA_W-1:0] sp_o
);
  logic              sm;
  logic              cond;
  logic [15:0]       status;
  logic [7:0]        bbst;
  logic              st_we, swap;
  logic [DATA_W-1:0] isp_slot, usp_slot;
  logic [DATA_W-1:0] scr_q  [SCR_N];
  logic [DATA_W-1:0] bkpc_q [BKPC_N];
  logic [SCR_N-1:0]  scr_we;
  logic [BKPC_N-1:0] bkpc_we;

  assign st_we   = wr_en_i && (wr_idx_i == IDX_STATUS);
  assign swap    = st_we && (wr_data_i[SM_BIT] != sm);
  assign scr_we  = {wr_en_i && (wr_idx_i == IDX_SCR1), wr_en_i && (wr_idx_i == IDX_SCR0)};
  assign bkpc_we = {wr_en_i && (wr_idx_i == IDX_BBPC), wr_en_i && (wr_idx_i == IDX_BPC)};

  crb_status #(.DATA_W(DATA_W)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .st_we_i   (st_we),
    .cond_we_i (wr_en_i && (wr_idx_i == IDX_COND)),
    .bb_we_i   (wr_en_i && (wr_idx_i == IDX_BBST)),
    .wdata_i   (wr_data_i),
    .status_o  (status),
    .bbst_o    (bbst),
    .cond_o    (cond),
    .sm_o      (sm)
  );

  crb_sp_bank #(.DATA_W(DATA_W)) u_sp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sm_i        (sm),
    .swap_i      (swap),
    .isp_we_i    (wr_en_i && (wr_idx_i == IDX_ISP)),
    .usp_we_i    (wr_en_i && (wr_idx_i == IDX_USP)),
    .wdata_i     (wr_data_i),
    .core_we_i   (sp_we_i),
    .core_data_i (sp_data_i),
    .live_o      (sp_o),
    .isp_slot_o  (isp_slot),
    .usp_slot_o  (usp_slot)
  );

  crb_store #(.DATA_W(DATA_W), .N(SCR_N), .CLR_LSB(1'b0)) u_scr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (scr_we),
    .wdata_i (wr_data_i),
    .q_o     (scr_q)
  );

  crb_store #(.DATA_W(DATA_W), .N(BKPC_N), .CLR_LSB(1'b1)) u_bkpc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bkpc_we),
    .wdata_i (wr_data_i),
    .q_o     (bkpc_q)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_idx_i)
      IDX_STATUS: rd_data_o = DATA_W'(status);
      IDX_COND:   rd_data_o = DATA_W'(cond);
      IDX_ISP:    rd_data_o = sm ? isp_slot : sp_o;
      IDX_USP:    rd_data_o = sm ? sp_o : usp_slot;
      IDX_SCR0:   rd_data_o = scr_q[0];
      IDX_SCR1:   rd_data_o = scr_q[1];
      IDX_BPC:    rd_data_o = bkpc_q[0];
      IDX_BBST:   rd_data_o = DATA_W'(bbst);
      IDX_BBPC:   rd_data_o = bkpc_q[1];
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/crb_checker.sv
module crb_checker
  import crb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        rd_idx_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              wr_en_i,
  input logic [3:0]        wr_idx_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              sp_we_i,
  input logic [DATA_W-1:0] sp_data_i,
  input logic [DATA_W-1:0] sp_o,
  input logic              sm,
  input logic [DATA_W-1:0] isp_slot,
  input logic [DATA_W-1:0] usp_slot
);
  logic st_wr;
  assign st_wr = wr_en_i && (wr_idx_i == IDX_STATUS);

  AST_SM_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_wr |=> (sm == $past(wr_data_i[SM_BIT]))); // R2

  AST_SWAP_TO_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && !sm && wr_data_i[SM_BIT]) |=>
      (sp_o == $past(usp_slot) && isp_slot == $past(sp_o))); // R4

  AST_SWAP_TO_INTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && sm && !wr_data_i[SM_BIT]) |=>
      (sp_o == $past(isp_slot) && usp_slot == $past(sp_o))); // R5

  AST_NO_SWAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && (wr_data_i[SM_BIT] == sm) && !sp_we_i) |=> $stable(sp_o)); // R6

  AST_BKPC_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_idx_i == IDX_BPC) || (rd_idx_i == IDX_BBPC)) |-> !rd_data_o[0]); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i > IDX_BBPC) |-> (rd_data_o == '0)); // R10

  AST_CORE_SP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_we_i && !wr_en_i) |=> (sp_o == $past(sp_data_i))); // R11
endmodule

bind ctrl_reg_bank crb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_idx_i  (rd_idx_i),
  .rd_data_o (rd_data_o),
  .wr_en_i   (wr_en_i),
  .wr_idx_i  (wr_idx_i),
  .wr_data_i (wr_data_i),
  .sp_we_i   (sp_we_i),
  .sp_data_i (sp_data_i),
  .sp_o      (sp_o),
  .sm        (sm),
  .isp_slot  (isp_slot),
  .usp_slot  (usp_slot)
);

// File: tb/sim_ctrl_reg_bank.sv
module sim_ctrl_reg_bank;
  localparam int unsigned DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [3:0]    rd_idx_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          wr_en_i = 1'b0;
  logic [3:0]    wr_idx_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic          sp_we_i = 1'b0;
  logic [DW-1:0] sp_data_i = '0;
  logic [DW-1:0] sp_o;

  int n_chk = 0;
  int n_bad = 0;

  // reference state, written from the requirements
  logic [7:0]    m_bst, m_st, m_bb;
  logic          m_cond;
  logic [DW-1:0] m_sp, m_isp, m_usp, m_s4, m_s5, m_bpc, m_bbpc;

  always #10 clk_i = ~clk_i; // 50 MHz

  ctrl_reg_bank #(.DATA_W(DW)) u0 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .sp_we_i   (sp_we_i),
    .sp_data_i (sp_data_i),
    .sp_o      (sp_o)
  );

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_rd(input int idx);
    case (idx)
      0: return {16'h0, m_bst & 8'hC1, (m_st & 8'hC0) | {7'b0, m_cond}};
      1: return DW'(m_cond);
      2: return m_st[7] ? m_isp : m_sp;
      3: return m_st[7] ? m_sp : m_usp;
      4: return m_s4;
      5: return m_s5;
      6: return m_bpc & ~DW'(1);
      7: return DW'(m_bb & 8'hC1);
      8: return m_bbpc & ~DW'(1);
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(input int idx);
    case (idx)
      0: return "R1";
      1, 4, 5: return "R9";
      2, 3: return "R3";
      6, 8: return "R7";
      7: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check_all(input string ovr);
    for (int i = 0; i < 16; i++) begin
      rd_idx_i = 4'(i);
      #1;
      chk((ovr != "") ? ovr : req_of(i), rd_data_o, exp_rd(i));
    end
    chk((ovr != "") ? ovr : "R11", sp_o, m_sp);
  endtask

  task automatic step(input logic we, input int idx, input logic [DW-1:0] d,
                      input logic spwe, input logic [DW-1:0] spd);
    logic old_sm;
    logic touch;
    wr_en_i = we; wr_idx_i = 4'(idx); wr_data_i = d;
    sp_we_i = spwe; sp_data_i = spd;
    @(posedge clk_i);
    #2;
    wr_en_i = 1'b0; sp_we_i = 1'b0;
    old_sm = m_st[7];
    touch  = 1'b0;
    if (we) begin
      case (idx)
        0: begin
          m_bst = d[15:8]; m_st = d[7:0]; m_cond = d[0];
          if (d[7] != old_sm) begin
            touch = 1'b1;
            if (old_sm) begin m_usp = m_sp; m_sp = m_isp; end
            else        begin m_isp = m_sp; m_sp = m_usp; end
          end
        end
        1: m_cond = d[0];
        2: if (!old_sm) begin m_sp = d; touch = 1'b1; end else m_isp = d;
        3: if (old_sm)  begin m_sp = d; touch = 1'b1; end else m_usp = d;
        4: m_s4 = d;
        5: m_s5 = d;
        6: m_bpc = d;
        7: m_bb = d[7:0];
        8: m_bbpc = d;
        default: ;
      endcase
    end
    if (spwe && !touch) m_sp = spd;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] pats [5];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'hA5A5_5AC3;
    pats[3] = 32'h5A5A_A53C; pats[4] = 32'h1357_9BDF;
    m_bst = '0; m_st = '0; m_bb = '0; m_cond = 1'b0;
    m_sp = '0; m_isp = '0; m_usp = '0; m_s4 = '0; m_s5 = '0; m_bpc = '0; m_bbpc = '0;

    repeat (3) @(posedge clk_i);
    #5;
    check_all("R12");            // in reset
    rst_ni = 1'b1;
    @(posedge clk_i); #2;
    check_all("R12");            // after release

    // sweep: every index with each pattern, core SP writes on odd indices
    for (int p = 0; p < 5; p++) begin
      for (int i = 0; i < 16; i++) begin
        step(1'b1, i, pats[p] ^ (32'h0101_0101 * i), i[0], ~pats[p] ^ 32'h0F0F_0000);
        check_all("");
      end
    end

    // directed swaps
    step(1'b1, 0, 32'h0, 1'b0, '0);
    step(1'b0, 0, '0, 1'b1, 32'h0000_1000);
    chk("R11", sp_o, 32'h0000_1000);
    step(1'b1, 3, 32'h0000_2000, 1'b0, '0);
    chk("R3", sp_o, 32'h0000_1000);
    step(1'b1, 0, 32'h0000_0080, 1'b0, '0);
    chk("R4", sp_o, 32'h0000_2000);
    rd_idx_i = 4'd2; #1; chk("R4", rd_data_o, 32'h0000_1000);
    rd_idx_i = 4'd3; #1; chk("R3", rd_data_o, 32'h0000_2000);
    step(1'b1, 0, 32'h0000_0000, 1'b0, '0);
    chk("R5", sp_o, 32'h0000_1000);
    rd_idx_i = 4'd3; #1; chk("R5", rd_data_o, 32'h0000_2000);
    step(1'b1, 0, 32'h0000_C141, 1'b0, '0);
    chk("R6", sp_o, 32'h0000_1000);
    rd_idx_i = 4'd0; #1; chk("R2", rd_data_o, 32'h0000_C141);
    step(1'b1, 2, 32'h0000_0AAA, 1'b1, 32'h0000_0BBB);
    chk("R11", sp_o, 32'h0000_0AAA);
    step(1'b1, 4, 32'h0000_0077, 1'b1, 32'h0000_0CCC);
    chk("R11", sp_o, 32'h0000_0CCC);
    rd_idx_i = 4'd4; #1; chk("R9", rd_data_o, 32'h0000_0077);
    check_all("");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule